// File: doc/BRIEF.md
# Reversible-Gate Binary Up Counter

This block is an N-bit binary up counter. Its next-state function is not an adder. It is an ordered chain of reversible gates that act in place on a set of N+1 lines. Line 0 carries the count request and line i+1 carries state bit i. The bit-0 stage is a controlled-NOT gate. Each higher bit i is flipped by a multi-control NOT gate whose controls are the request line and every state bit below i. The gates are applied from the most significant target down to bit 0, so each gate still sees the unmodified lower bits. The chain is a bijection on all of its lines.

The outputs of the chain are duplicated by one controlled-NOT copy gate per bit into a zero-initialised ancilla line. The copy drives the state register, and the original line is brought out as the next-state value. The count request comes from a level input. An edge detector turns each high pulse of that level into a single one-cycle request, so one pulse gives one increment no matter how long it lasts. The block also reports how many gates the structure uses and how many of its lines are garbage.

Top module: `rcnt_counter`

## Requirements
- R1: A synchronous active-high reset `rst` loads the all-zero state; one clock after `rst` is high, `state_q` reads 0.
- R2: While `cnt_en` is low, `state_q` does not change and `next_q` equals `state_q`.
- R3: In the cycle in which `cnt_en` is high after being low at the previous clock edge, the following clock edge loads `state_q + 1` modulo 2^N. For N = 3 the value 7 (binary 111) steps to 0.
- R4: A level of `cnt_en` held high over several clock edges advances the state only once. A further step needs `cnt_en` to go low and high again.
- R5: `next_q` is combinational in the present state and the request line c, which is 1 only in the first high cycle of `cnt_en`. Bit 0 is c XOR q0. Bit i > 0 is (c AND q0 AND ... AND q(i-1)) XOR qi. The next clock edge loads `next_q` into `state_q` when `rst` is low.
- R6: `en_pass` is the request line after the chain and equals c unchanged: 1 only in the first high cycle of `cnt_en`.
- R7: `gate_count` reads 2N (N chain gates plus N copy gates) and `garbage_count` reads 1 (the request line).
- R8: The descending chain `rcnt_cascade` with ORDER = ORD_DESC is a bijection on its N+1 lines, where bit 0 is the request and bit i+1 is state bit i. The same gates in the ascending order (ORD_ASC) map its output back to its input for all 2^(N+1) patterns.
- R9: The ascending order alone is not a counter. For N = 3 with request 1 and state 001 it yields state 000, while the descending order yields 010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the state register loads on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count level; each high pulse requests one increment |
| state_q | output | N | Present counter state |
| next_q | output | N | Next-state lines from the gate chain |
| en_pass | output | 1 | Request line passed through the chain |
| gate_count | output | 8 | Number of reversible gates used (2N) |
| garbage_count | output | 8 | Number of garbage lines (1) |

## Verification
The hardest case to reach is the rule that one long high level of `cnt_en` counts only once. This needs stimulus that holds the level over many clock edges and then checks that the state moved a single step. The bench does this and also releases and re-raises the level at the wrap from 7 to 0. The ordering claims cannot be seen at the top ports, so the bench drives stand-alone copies of the chain in both orders with every line pattern. It checks that the ascending chain undoes the descending one, and that the ascending chain alone gives a wrong count.

// File: rtl/rcnt_pkg.sv
package rcnt_pkg;

    // Order in which the multi-control gates are applied along the chain
    typedef enum logic {
        ORD_DESC = 1'b0,   // most significant target first (counting order)
        ORD_ASC  = 1'b1    // bit 0 first (inverse of ORD_DESC)
    } order_e;

    localparam int COST_W = 8;

    typedef struct packed {
        logic [COST_W-1:0] gates;
        logic [COST_W-1:0] garbage;
    } cost_t;

    // Line index targeted by the k-th gate of an n-bit chain.
    // Line 0 is the request, line i+1 holds state bit i.
    function automatic int target_line(input int n, input int k, input order_e ord);
        return (ord == ORD_DESC) ? (n - k) : (k + 1);
    endfunction

    // Structural cost of an n-bit counter: chain gates plus copy gates,
    // and the request line as the only garbage line.
    function automatic cost_t counter_cost(input int n);
        cost_t c;
        c.gates   = COST_W'(2 * n);
        c.garbage = COST_W'(1);
        return c;
    endfunction

endpackage

// File: rtl/rcnt_gate.sv
// One in-place multi-control NOT gate: line TGT is inverted when every
// line below it is 1. With TGT = 1 this is a plain controlled-NOT.
module rcnt_gate #(
    parameter int W   = 4,
    parameter int TGT = 1
) (
    input  logic [W-1:0] lines_i,
    output logic [W-1:0] lines_o
);
    localparam logic [W-1:0] CTRL_MASK = W'((1 << TGT) - 1);

    logic fire;

    always_comb begin
        fire          = &(lines_i | ~CTRL_MASK);
        lines_o       = lines_i;
        lines_o[TGT]  = lines_i[TGT] ^ fire;
    end
endmodule

// File: rtl/rcnt_cascade.sv
// Ordered chain of N reversible gates on N+1 lines.
module rcnt_cascade
    import rcnt_pkg::*;
#(
    parameter int     N     = 3,
    parameter order_e ORDER = ORD_DESC
) (
    input  logic [N:0] lines_i,
    output logic [N:0] lines_o
);
    localparam int W = N + 1;

    logic [N:0][W-1:0] stage;

    assign stage[0] = lines_i;

    for (genvar k = 0; k < N; k++) begin : g_stage
        localparam int TGT = target_line(N, k, ORDER);
        rcnt_gate #(
            .W   (W),
            .TGT (TGT)
        ) u_gate (
            .lines_i (stage[k]),
            .lines_o (stage[k+1])
        );
    end

    assign lines_o = stage[N];
endmodule

// File: rtl/rcnt_copy.sv
// Controlled-NOT fan-out: each source line controls a gate whose target
// is a zero ancilla, giving a pass-through line and an identical copy.
module rcnt_copy #(
    parameter int N = 3
) (
    input  logic [N-1:0] src_i,
    output logic [N-1:0] pass_o,
    output logic [N-1:0] copy_o
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic ancilla;
        assign ancilla   = 1'b0;
        assign pass_o[b] = src_i[b];
        assign copy_o[b] = ancilla ^ src_i[b];
    end
endmodule

// File: rtl/rcnt_pulse.sv
// Turns a level into a request that is high only in its first cycle.
module rcnt_pulse (
    input  logic clk,
    input  logic level_i,
    output logic pulse_o
);
    logic level_q;

    always_ff @(posedge clk) begin
        level_q <= level_i;
    end

    assign pulse_o = level_i & ~level_q;
endmodule

// File: rtl/rcnt_counter.sv
module rcnt_counter
    import rcnt_pkg::*;
#(
    parameter int N = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    output logic [N-1:0]      state_q,
    output logic [N-1:0]      next_q,
    output logic              en_pass,
    output logic [COST_W-1:0] gate_count,
    output logic [COST_W-1:0] garbage_count
);
    localparam int    W    = N + 1;
    localparam cost_t COST = counter_cost(N);

    logic          req;
    logic [W-1:0]  lines_in;
    logic [W-1:0]  lines_out;
    logic [N-1:0]  fb_copy;
    logic [N-1:0]  state_r;

    rcnt_pulse u_pulse (
        .clk     (clk),
        .level_i (cnt_en),
        .pulse_o (req)
    );

    assign lines_in = {state_r, req};

    rcnt_cascade #(
        .N     (N),
        .ORDER (ORD_DESC)
    ) u_chain (
        .lines_i (lines_in),
        .lines_o (lines_out)
    );

    rcnt_copy #(
        .N (N)
    ) u_copy (
        .src_i  (lines_out[W-1:1]),
        .pass_o (next_q),
        .copy_o (fb_copy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_r <= '0;
        end else begin
            state_r <= fb_copy;
        end
    end

    assign state_q       = state_r;
    assign en_pass       = lines_out[0];
    assign gate_count    = COST.gates;
    assign garbage_count = COST.garbage;
endmodule

// File: rtl/rcnt_counter_chk.sv
module rcnt_counter_chk #(
    parameter int N = 3
) (
    input logic         clk,
    input logic         rst,
    input logic         cnt_en,
    input logic [N-1:0] state_q,
    input logic [N-1:0] next_q,
    input logic         en_pass
);
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (state_q == '0));

    a_r2_hold_low: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(state_q));

    a_r2_next_idle: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |-> (next_q == state_q));

    a_r3_step_one: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !$past(cnt_en)) |=> (state_q == $past(state_q) + 1'b1));

    a_r4_once_per_pulse: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && $past(cnt_en)) |=> $stable(state_q));

    a_r5_reg_loads_next: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (state_q == $past(next_q)));

    a_r6_request_line: assert property (@(posedge clk) disable iff (rst)
        en_pass == (cnt_en && !$past(cnt_en)));
endmodule

bind rcnt_counter rcnt_counter_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cnt_en  (cnt_en),
    .state_q (state_q),
    .next_q  (next_q),
    .en_pass (en_pass)
);

// File: tb/rcnt_counter_tb.sv
module rcnt_counter_tb;
    import rcnt_pkg::*;

    localparam int N = 3;
    localparam int W = N + 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cnt_en = 1'b0;
    logic [N-1:0]      state_q, next_q;
    logic              en_pass;
    logic [COST_W-1:0] gate_count, garbage_count;

    logic [W-1:0] pat = '0;
    logic [W-1:0] fwd_out, inv_out, asc_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int exp_state = 0;

    always #10 clk = ~clk;

    rcnt_counter #(.N(N)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .cnt_en        (cnt_en),
        .state_q       (state_q),
        .next_q        (next_q),
        .en_pass       (en_pass),
        .gate_count    (gate_count),
        .garbage_count (garbage_count)
    );

    rcnt_cascade #(.N(N), .ORDER(ORD_DESC)) u_fwd (.lines_i(pat),     .lines_o(fwd_out));
    rcnt_cascade #(.N(N), .ORDER(ORD_ASC))  u_inv (.lines_i(fwd_out), .lines_o(inv_out));
    rcnt_cascade #(.N(N), .ORDER(ORD_ASC))  u_asc (.lines_i(pat),     .lines_o(asc_out));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cnt_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_state = 0;
        chk("R1 state after reset", state_q, 0);
        chk("R2 next_q idle after reset", next_q, 0);
    endtask

    task automatic t_costs();
        chk("R7 gate_count", gate_count, 2 * N);
        chk("R7 garbage_count", garbage_count, 1);
    endtask

    task automatic t_hold();
        cnt_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R2 state held with enable low", state_q, exp_state);
            chk("R2 next_q equals state", next_q, exp_state);
            chk("R6 request line low", en_pass, 0);
        end
    endtask

    task automatic pulse_once();
        int nxt;
        nxt = (exp_state + 1) % (1 << N);
        cnt_en = 1'b1;
        #2;
        chk("R5 next_q during request", next_q, nxt);
        chk("R6 request line high", en_pass, 1);
        @(negedge clk);
        if (exp_state == (1 << N) - 1)
            chk("R3 wrap 111 to 000", state_q, nxt);
        else
            chk("R3 step by one", state_q, nxt);
        exp_state = nxt;
        cnt_en = 1'b0;
        @(negedge clk);
        chk("R2 state held after pulse", state_q, exp_state);
    endtask

    task automatic t_count_wrap();
        for (int i = 0; i < 10; i++) pulse_once();
    endtask

    task automatic t_held_high();
        int start;
        start = exp_state;
        pulse_once();
        cnt_en = 1'b1;
        @(negedge clk);
        exp_state = (start + 2) % (1 << N);
        chk("R4 first edge of long level counts", state_q, exp_state);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R4 long level counts once", state_q, exp_state);
            chk("R6 request low while level held", en_pass, 0);
            chk("R5 next_q equals state while held", next_q, exp_state);
        end
        cnt_en = 1'b0;
        @(negedge clk);
        pulse_once();
    endtask

    task automatic t_reset_midrun();
        while (exp_state == 0) pulse_once();
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset from nonzero state", state_q, 0);
        rst = 1'b0;
        exp_state = 0;
        @(negedge clk);
        chk("R1 state stays zero after reset", state_q, 0);
    endtask

    task automatic t_bijection();
        for (int p = 0; p < (1 << W); p++) begin
            int q, c, ex;
            pat = W'(p);
            #1;
            q  = p >> 1;
            c  = p & 1;
            ex = c ? ((q + 1) % (1 << N)) : q;
            chk("R8 descending chain counts", int'(fwd_out) >> 1, ex);
            chk("R8 ascending chain inverts descending", int'(inv_out), p);
        end
    endtask

    task automatic t_ascending_wrong();
        pat = {3'b001, 1'b1};
        #1;
        chk("R9 ascending order state", int'(asc_out) >> 1, 0);
        chk("R9 descending order state", int'(fwd_out) >> 1, 2);
    endtask

    initial begin
        t_reset();
        t_costs();
        t_hold();
        t_count_wrap();
        t_held_high();
        t_hold();
        t_reset_midrun();
        t_bijection();
        t_ascending_wrong();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(64'd20 * 64'd200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule